// File: doc/BRIEF.md
# Dual-Network First-Wins Duplicate Filter

This block takes two frame-descriptor streams, one from each of two redundant networks (A and B), and merges them into a single stream toward the consuming application. Each descriptor carries a virtual-link (VL) index and an 8-bit sequence number. Payload handling is not part of the block. For each VL it remembers the last sequence number it has delivered. When duplicate suppression is switched on for that VL, the first copy of a frame to arrive from either network is forwarded and the late copy is discarded. When suppression is off, both copies are forwarded.

Every port that moves data is a valid/ready stream. A descriptor is taken on a rising edge where its valid and ready are both high. `a_ready` and `b_ready` are always equal: they are high whenever the internal output queue has at least two free slots, so a frame from each network can be taken in the same cycle. On the output, data is held stable while `out_valid` is high and `out_ready` is low. An entry leaves on a rising edge where both are high. The per-VL enable vector `rm_enable` is a plain level control.

Sequence numbers advance through 1..255 and then wrap back to 1. The value 0 marks a restart by the sender. Frames with sequence 0 are always forwarded, and they clear the tracking for their VL.

Top module: `rm_first_wins_filter`

## Requirements
- R1: During reset and after it, `out_valid` is 0 and `a_ready`/`b_ready` are 1 until a frame is accepted.
- R2: With `rm_enable[v]`=1, a frame on VL v whose sequence equals the last delivered sequence of v is dropped, whichever network carries it.
- R3: With `rm_enable[v]`=0, every accepted frame on VL v is forwarded, including exact copies.
- R4: A frame with sequence 0 is always forwarded. It clears the tracking of its VL, so the next frame on that VL is forwarded whatever its number.
- R5: With suppression on and tracking active, a frame is dropped when its sequence is the last delivered value or one or two steps behind it. Steps are counted on the ring 1..255, where 255 is one step behind 1. Frames three or more steps behind, or ahead, are forwarded and become the new last value.
- R6: When A and B both present a frame in the same cycle, A is judged first and B is judged against the state A left. If both are forwarded, A's entry comes out before B's.
- R7: Tracking is kept separately for each VL. Frames on one VL never change what is dropped on another.
- R8: The input ready signals are low while fewer than two queue slots are free. Output data holds steady under back-pressure. No forwarded frame is lost or reordered.
- R9: A forwarded frame accepted into an empty queue shows `out_valid`=1 in the cycle after its acceptance edge.
- R10: The first frame on a VL after reset is forwarded.
- R11: `out_net` is 0 for a frame taken from network A and 1 for one taken from network B. `out_vl` and `out_seq` repeat the frame's VL and sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rm_enable | input | NUM_VL | Per-VL duplicate suppression enable |
| a_valid | input | 1 | Network A descriptor valid |
| a_ready | output | 1 | Network A may present a descriptor |
| a_vl | input | VL_W | Network A VL index |
| a_seq | input | 8 | Network A sequence number |
| b_valid | input | 1 | Network B descriptor valid |
| b_ready | output | 1 | Network B may present a descriptor |
| b_vl | input | VL_W | Network B VL index |
| b_seq | input | 8 | Network B sequence number |
| out_valid | output | 1 | Merged descriptor valid |
| out_ready | input | 1 | Consumer accepts merged descriptor |
| out_vl | output | VL_W | Merged VL index |
| out_seq | output | 8 | Merged sequence number |
| out_net | output | 1 | Source network, 0 = A, 1 = B |

## Verification
The case that is hardest to reach is a window comparison against an arbitrary remembered value near the wrap point. The stored value can only be set by frames that pass the filter. The stimulus therefore first sends a sequence-0 frame to clear tracking, then a frame carrying the chosen last value, and then sweeps the probe number over all of 1..255. This is repeated for several last values, including 1, 2, 254 and 255. Same-cycle A/B pairs on one VL are driven with both valids raised on a single edge. This exposes whether B is judged against A's update.

// File: rtl/rm_pkg.sv
package rm_pkg;
  localparam int SEQ_W    = 8;
  localparam int SEQ_RING = (1 << SEQ_W) - 1;   // count of nonzero sequence values

  typedef logic [SEQ_W-1:0] seq_t;

  typedef enum logic {NET_A = 1'b0, NET_B = 1'b1} net_e;

  typedef struct packed {
    logic tracking;
    seq_t last;
  } vl_state_t;

  // Steps from 'probe' forward to 'ref_seq' on the ring 1..SEQ_RING.
  function automatic int unsigned ring_behind(seq_t ref_seq, seq_t probe);
    if (ref_seq >= probe) return int'(ref_seq) - int'(probe);
    else                  return int'(ref_seq) + SEQ_RING - int'(probe);
  endfunction
endpackage

// File: rtl/rm_dup_judge.sv
module rm_dup_judge
  import rm_pkg::*;
#(
  parameter int WINDOW = 2
) (
  input  logic      enable,
  input  vl_state_t cur,
  input  seq_t      seq,
  output logic      forward,
  output vl_state_t nxt
);
  logic          restart;
  logic          in_window;
  int unsigned   gap;

  always_comb begin
    restart   = (seq == '0);
    gap       = ring_behind(cur.last, seq);
    in_window = (gap <= WINDOW);
    forward   = !(enable && cur.tracking && !restart && in_window);
    nxt       = cur;
    if (forward) begin
      if (restart) begin
        nxt.tracking = 1'b0;
        nxt.last     = '0;
      end else begin
        nxt.tracking = 1'b1;
        nxt.last     = seq;
      end
    end
  end
endmodule

// File: rtl/rm_vl_table.sv
module rm_vl_table
  import rm_pkg::*;
#(
  parameter int NUM_VL = 8,
  parameter int WINDOW = 2,
  localparam int VL_W  = (NUM_VL > 1) ? $clog2(NUM_VL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VL-1:0] rm_enable,
  input  logic              a_fire,
  input  logic [VL_W-1:0]   a_vl,
  input  seq_t              a_seq,
  input  logic              b_fire,
  input  logic [VL_W-1:0]   b_vl,
  input  seq_t              b_seq,
  output logic              a_forward,
  output logic              b_forward
);
  vl_state_t state [NUM_VL];
  vl_state_t cur_a, cur_b, nxt_a, nxt_b;
  logic      fwd_a, fwd_b;
  logic      same_vl;

  assign same_vl = a_fire && (a_vl == b_vl);

  always_comb begin
    cur_a = state[a_vl];
    cur_b = same_vl ? nxt_a : state[b_vl];
  end

  rm_dup_judge #(.WINDOW(WINDOW)) u_judge_a (
    .enable (rm_enable[a_vl]),
    .cur    (cur_a),
    .seq    (a_seq),
    .forward(fwd_a),
    .nxt    (nxt_a)
  );

  rm_dup_judge #(.WINDOW(WINDOW)) u_judge_b (
    .enable (rm_enable[b_vl]),
    .cur    (cur_b),
    .seq    (b_seq),
    .forward(fwd_b),
    .nxt    (nxt_b)
  );

  assign a_forward = a_fire && fwd_a;
  assign b_forward = b_fire && fwd_b;

  for (genvar v = 0; v < NUM_VL; v++) begin : g_vl
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        state[v] <= '0;
      end else if (b_fire && (b_vl == VL_W'(v))) begin
        state[v] <= nxt_b;
      end else if (a_fire && (a_vl == VL_W'(v))) begin
        state[v] <= nxt_a;
      end
    end
  end

  // R6: a same-VL pair carrying one nonzero number under suppression yields one copy
  a_r6_pair_single: assert property (@(posedge clk) disable iff (!rst_n)
    (a_forward && b_fire && same_vl && rm_enable[a_vl] && a_seq == b_seq && a_seq != '0)
      |-> !b_forward);

  // R4: sequence zero always passes
  a_r4_zero_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (a_fire && a_seq == '0) |-> a_forward);

  // R3: suppression off forwards everything
  a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (b_fire && !rm_enable[b_vl]) |-> b_forward);
endmodule

// File: rtl/rm_pair_fifo.sv
module rm_pair_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push0,
  input  logic [W-1:0] d0,
  input  logic         push1,
  input  logic [W-1:0] d1,
  input  logic         pop,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         room2
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr, rd, wr_next1;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_next1  = step(wr);
  assign out_valid = (count != '0);
  assign out_data  = mem[rd];
  assign room2     = (count <= CW'(DEPTH - 2));

  always_ff @(posedge clk) begin
    if (push0) mem[wr] <= d0;
    if (push1) mem[push0 ? wr_next1 : wr] <= d1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr    <= '0;
      rd    <= '0;
      count <= '0;
    end else begin
      if (push0 && push1)      wr <= step(wr_next1);
      else if (push0 || push1) wr <= wr_next1;
      if (pop)                 rd <= step(rd);
      count <= count + CW'(push0) + CW'(push1) - CW'(pop);
    end
  end

  // R8: held entry stays unchanged until taken
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pop) |=> (out_valid && $stable(out_data)));

  // R9: a pushed entry is visible the next cycle
  a_r9_push_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (push0 || push1) |=> out_valid);

  // R8: never more entries than slots
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> !(push0 && !pop));
endmodule

// File: rtl/rm_first_wins_filter.sv
module rm_first_wins_filter
  import rm_pkg::*;
#(
  parameter int NUM_VL     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int DUP_WINDOW = 2,
  localparam int VL_W      = (NUM_VL > 1) ? $clog2(NUM_VL) : 1,
  localparam int ENT_W     = 1 + VL_W + SEQ_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VL-1:0] rm_enable,
  input  logic              a_valid,
  output logic              a_ready,
  input  logic [VL_W-1:0]   a_vl,
  input  logic [SEQ_W-1:0]  a_seq,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic [VL_W-1:0]   b_vl,
  input  logic [SEQ_W-1:0]  b_seq,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VL_W-1:0]   out_vl,
  output logic [SEQ_W-1:0]  out_seq,
  output logic              out_net
);
  logic             room2;
  logic             a_fire, b_fire;
  logic             a_forward, b_forward;
  logic [ENT_W-1:0] ent_a, ent_b, ent_out;
  logic             pop;

  assign a_ready = room2;
  assign b_ready = room2;
  assign a_fire  = a_valid && room2;
  assign b_fire  = b_valid && room2;
  assign pop     = out_valid && out_ready;

  assign ent_a = {NET_A, a_vl, a_seq};
  assign ent_b = {NET_B, b_vl, b_seq};

  rm_vl_table #(.NUM_VL(NUM_VL), .WINDOW(DUP_WINDOW)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rm_enable(rm_enable),
    .a_fire   (a_fire),
    .a_vl     (a_vl),
    .a_seq    (a_seq),
    .b_fire   (b_fire),
    .b_vl     (b_vl),
    .b_seq    (b_seq),
    .a_forward(a_forward),
    .b_forward(b_forward)
  );

  rm_pair_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push0    (a_forward),
    .d0       (ent_a),
    .push1    (b_forward),
    .d1       (ent_b),
    .pop      (pop),
    .out_valid(out_valid),
    .out_data (ent_out),
    .room2    (room2)
  );

  assign {out_net, out_vl, out_seq} = ent_out;

  // R8: inputs are refused while the queue is nearly full
  a_r8_refuse_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !a_ready) |=> !a_ready);
endmodule

// File: tb/rm_first_wins_filter_test.sv
module rm_first_wins_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam int VW = 2;
  localparam int MAXE = 16384;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NV-1:0] rm_en = '1;
  logic          a_valid = 1'b0, b_valid = 1'b0;
  logic          a_ready, b_ready;
  logic [VW-1:0] a_vl = '0, b_vl = '0;
  logic [7:0]    a_seq = '0, b_seq = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [VW-1:0] out_vl;
  logic [7:0]    out_seq;
  logic          out_net;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rm_first_wins_filter #(.NUM_VL(NV), .FIFO_DEPTH(4), .DUP_WINDOW(2)) uut (
    .clk(clk), .rst_n(rst_n), .rm_enable(rm_en),
    .a_valid(a_valid), .a_ready(a_ready), .a_vl(a_vl), .a_seq(a_seq),
    .b_valid(b_valid), .b_ready(b_ready), .b_vl(b_vl), .b_seq(b_seq),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_vl(out_vl), .out_seq(out_seq), .out_net(out_net)
  );

  int total = 0;
  int bad = 0;
  int nexp = 0;
  int ngot = 0;
  int mode = 0;
  string cur_req = "R10";
  int exp_vl [MAXE];
  int exp_seq [MAXE];
  int exp_net [MAXE];
  string exp_tag [MAXE];
  bit trk [NV];
  int lst [NV];
  logic [15:0] lfsr = 16'hACE1;
  bit held = 0;
  logic [10:0] held_data;

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Reference rule taken from R2..R5, R10
  function automatic bit model_take(int vl, int s, bit en);
    int gap;
    bit dup;
    gap = (lst[vl] >= s) ? lst[vl] - s : lst[vl] + 255 - s;
    dup = en && trk[vl] && (s != 0) && (gap <= 2);
    if (!dup) begin
      if (s == 0) begin trk[vl] = 0; lst[vl] = 0; end
      else        begin trk[vl] = 1; lst[vl] = s; end
    end
    return !dup;
  endfunction

  function automatic void expect_out(int vl, int s, int net);
    exp_vl[nexp] = vl; exp_seq[nexp] = s; exp_net[nexp] = net;
    exp_tag[nexp] = cur_req;
    nexp++;
  endfunction

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic send(bit av, int avl, int aseq, bit bv, int bvl, int bseq);
    while (!a_ready) @(negedge clk);
    a_valid = av; a_vl = VW'(avl); a_seq = 8'(aseq);
    b_valid = bv; b_vl = VW'(bvl); b_seq = 8'(bseq);
    if (av && model_take(avl, aseq, rm_en[avl])) expect_out(avl, aseq, 0);
    if (bv && model_take(bvl, bseq, rm_en[bvl])) expect_out(bvl, bseq, 1);
    @(negedge clk);
    a_valid = 0; b_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && ngot != nexp; i++) @(negedge clk);
  endtask

  // Output monitor and consumer
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (mode == 0)      out_ready = 1'b1;
      else if (mode == 1) out_ready = lfsr[0];
      else                out_ready = 1'b0;
      if (held) begin
        chk(out_valid && ({out_net, out_vl, out_seq} == held_data), "R8 hold",
            int'({out_net, out_vl, out_seq}), int'(held_data));
      end
      held = out_valid && !out_ready;
      held_data = {out_net, out_vl, out_seq};
      if (out_valid && out_ready) begin
        if (ngot >= nexp) begin
          chk(0, "R2 extra output", int'(out_seq), -1);
        end else begin
          chk(out_seq == 8'(exp_seq[ngot]), {exp_tag[ngot], " seq"}, int'(out_seq), exp_seq[ngot]);
          chk(out_vl == VW'(exp_vl[ngot]), {exp_tag[ngot], " vl R7"}, int'(out_vl), exp_vl[ngot]);
          chk(out_net == 1'(exp_net[ngot]), {exp_tag[ngot], " net R11"}, int'(out_net), exp_net[ngot]);
        end
        ngot++;
      end
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < NV; v++) begin trk[v] = 0; lst[v] = 0; end
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && a_ready && b_ready, "R1 after reset",
        int'({out_valid, a_ready, b_ready}), 3);

    // R9 and R10: first frame after reset, one-cycle latency
    cur_req = "R10";
    send(1, 0, 9, 0, 0, 0);
    chk(out_valid, "R9 latency", int'(out_valid), 1);
    drain();

    // R2: late copy on the other network is dropped
    cur_req = "R2";
    send(1, 1, 5, 0, 0, 0);
    send(0, 0, 0, 1, 1, 5);
    send(0, 0, 0, 1, 1, 6);
    send(1, 1, 6, 0, 0, 0);
    // R3: suppression off on VL 2 forwards both copies
    cur_req = "R3";
    rm_en[2] = 1'b0;
    send(1, 2, 5, 0, 0, 0);
    send(0, 0, 0, 1, 2, 5);
    // R6: same-cycle pair, A wins, B sees A's update
    cur_req = "R6";
    send(1, 3, 7, 1, 3, 7);
    send(1, 2, 8, 1, 2, 8);
    send(1, 3, 9, 1, 3, 10);
    // R4: restart with zero
    cur_req = "R4";
    send(0, 0, 0, 1, 1, 4);
    send(1, 1, 0, 0, 0, 0);
    send(0, 0, 0, 1, 1, 4);
    send(1, 1, 0, 1, 1, 0);
    drain();

    // R5: sweep probe against chosen last values on VL 0
    cur_req = "R5";
    foreach (lst[k]) if (k == 0) rm_en[0] = 1'b1;
    for (int li = 0; li < 6; li++) begin
      int lastv;
      case (li)
        0: lastv = 1;   1: lastv = 2;   2: lastv = 3;
        3: lastv = 128; 4: lastv = 254; default: lastv = 255;
      endcase
      for (int s = 1; s < 256; s++) begin
        send(1, 0, 0, 0, 0, 0);
        send(1, 0, lastv, 0, 0, 0);
        send(0, 0, 0, 1, 0, s);
      end
    end
    drain();

    // R7: interleaved VLs with mixed enables, random back-pressure (R8)
    cur_req = "R7";
    rm_en = 4'b1011;
    mode = 1;
    for (int i = 0; i < 400; i++) begin
      int v, s;
      v = i % NV;
      s = ((i / NV) % 255) + 1;
      if (i % 3 == 0) send(1, v, s, 1, v, s);
      else if (i % 3 == 1) send(1, v, s, 1, (v + 1) % NV, s);
      else send(0, 0, 0, 1, v, s);
    end
    mode = 0;
    drain();

    // R8: full queue refuses input
    cur_req = "R8";
    mode = 2;
    @(negedge clk);
    send(1, 2, 20, 1, 2, 20);
    send(1, 2, 21, 1, 2, 21);
    repeat (2) @(negedge clk);
    chk(!a_ready && !b_ready, "R8 ready low when full", int'({a_ready, b_ready}), 0);
    chk(out_valid, "R8 valid held", int'(out_valid), 1);
    mode = 0;
    drain();

    chk(ngot == nexp, "R8 count delivered", ngot, nexp);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule